// File: doc/BRIEF.md
# Leveled Interrupt Request Controller

This block collects interrupt events from a set of peripheral sources and decides which one, if any, the processor should take next. Every source owns a pending flag and a three-bit level. An event always latches the pending flag, whatever the level of that source and whatever the state of the global enable. Among pending sources with a non-zero level, a fixed arbitration picks a winner. The winner is offered to the processor only while the global enable is set and its level is strictly above the level currently being serviced.

The processor is reduced to two strobes. An acknowledge pulse takes the offered source: its pending flag drops at once, the global enable and the current level are saved, the enable is cleared, and the current level is raised to the winner's level. A return pulse puts the saved enable and level back in one cycle. Because the flag clears at acknowledge and not at the end of service, an event that lands during service sets the flag again. The same source is therefore offered again right after the return.

Software reaches the block through a per-source write that carries a new level and a pending bit, and through a separate write of the global enable.

Top module: `irq_prio_ctrl`

## Requirements
- R1: An event on `evt_i[k]` sets pending flag k on the next clock edge, regardless of source k's level, the global enable or the current level.
- R2: Levels run from 0 to 7, with 7 the most urgent. A pending source whose level is 0 never wins arbitration and is never offered.
- R3: `irq_o` is 1 exactly when the global enable is 1 and the arbitration winner's level is strictly greater than `cur_lvl_o`. A winner whose level equals the current level is not offered.
- R4: The winner is the pending source with the highest non-zero level, with ties going to the lowest index. `irq_id_o` and `irq_lvl_o` show the winner whether or not it is offered, and both read 0 when no pending source has a non-zero level.
- R5: An acknowledge while `irq_o` is 1 does four things on the next edge. It clears the winner's pending flag, saves the global enable and current level, clears the global enable, and sets `cur_lvl_o` to the winner's level.
- R6: An acknowledge while `irq_o` is 0 changes neither the flags, the global enable nor the current level.
- R7: A software write to source k (`sw_wr_i` with `sw_idx_i`=k) loads its level from `sw_lvl_i`. A pending bit of 0 clears flag k, while a pending bit of 1 leaves the flag as it was.
- R8: When an event on source k coincides with a clear of flag k, the event wins and the flag stays 1. The clear may come from a software write or from an acknowledge.
- R9: A return pulse restores the saved global enable and level on the next edge and takes precedence over an acknowledge in the same cycle; the acknowledge is then dropped. An event that arrived during service is therefore offered again right after the return.
- R10: After reset all pending flags and levels are 0, the global enable is 0 and the current level is 0.
- R11: `gen_wr_i` loads the global enable from `gen_val_i`, unless a return or a taken acknowledge in the same cycle sets the enable itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | N | Per-source event pulses |
| sw_wr_i | input | 1 | Software write strobe for one source |
| sw_idx_i | input | ID_W | Source addressed by the software write |
| sw_pend_i | input | 1 | Pending bit written (0 clears, 1 has no effect) |
| sw_lvl_i | input | 3 | Level written to the addressed source |
| gen_wr_i | input | 1 | Software write strobe for the global enable |
| gen_val_i | input | 1 | Global enable value written |
| ack_i | input | 1 | Processor acknowledge pulse |
| ret_i | input | 1 | Processor return-from-service pulse |
| irq_o | output | 1 | A request is offered to the processor |
| irq_id_o | output | ID_W | Index of the arbitration winner |
| irq_lvl_o | output | 3 | Level of the arbitration winner |
| gie_o | output | 1 | Global enable |
| cur_lvl_o | output | 3 | Level currently being serviced |
| pend_o | output | N | Pending flags |

## Verification
Arbitration is tried with four kinds of pending set: a single pending source, two sources tied at one level, one source raised above the rest, and a pending source parked at level 0. Together these separate "highest level" from "lowest index" and show that level 0 drops out. Acceptance is tried with the enable off, with a winner equal to the current level, and with a winner above it, which pins down the strict comparison. The coincidence patterns are applied as well: an event together with an acknowledge, an event together with a software clear, and a return together with an acknowledge. They show which side wins, and that a flag set during service brings the same source back right after the return.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;
   localparam int LVL_W   = 3;
   localparam int LVL_TOP = (1 << LVL_W) - 1;

   typedef logic [LVL_W-1:0] lvl_t;

   // processor context captured at acknowledge
   typedef struct packed {
      logic gie;
      lvl_t lvl;
   } ctx_t;

   localparam lvl_t LVL_OFF = '0;
endpackage

// File: rtl/irq_req_bank.sv
`timescale 1ns/1ps
module irq_req_bank
   import irq_prio_pkg::*;
#(
   parameter int N    = 8,
   parameter int ID_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     evt_i,
   input  logic             sw_wr_i,
   input  logic [ID_W-1:0]  sw_idx_i,
   input  logic             sw_pend_i,
   input  lvl_t             sw_lvl_i,
   input  logic             ack_clr_i,
   input  logic [ID_W-1:0]  ack_idx_i,
   output logic [N-1:0]     pend_o,
   output lvl_t [N-1:0]     lvl_o
);

   if (N < 1) begin : g_bad_n
      $error("irq_req_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_src
      logic pend_r;
      lvl_t lvl_r;
      logic sel_sw;
      logic clr_hit;

      assign sel_sw  = sw_wr_i && (sw_idx_i == ID_W'(i));
      assign clr_hit = (sel_sw && !sw_pend_i) ||
                       (ack_clr_i && (ack_idx_i == ID_W'(i)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_r <= 1'b0;
         end else if (evt_i[i]) begin
            pend_r <= 1'b1;          // hardware set dominates any clear
         end else if (clr_hit) begin
            pend_r <= 1'b0;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_r <= LVL_OFF;
         end else if (sel_sw) begin
            lvl_r <= sw_lvl_i;
         end
      end

      assign pend_o[i] = pend_r;
      assign lvl_o[i]  = lvl_r;

      // R1
      evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt_i[i] |=> pend_r);

      // R7
      sw_one_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_sw && sw_pend_i && !evt_i[i] && !pend_r &&
          !(ack_clr_i && ack_idx_i == ID_W'(i))) |=> !pend_r);

      // R8
      set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_hit && evt_i[i]) |=> pend_r);
   end

endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
   import irq_prio_pkg::*;
#(
   parameter int N         = 8,
   parameter int ID_W      = (N > 1) ? $clog2(N) : 1,
   parameter bit ARB_SPLIT = 1'b1
) (
   input  logic [N-1:0]    pend_i,
   input  lvl_t [N-1:0]    lvl_i,
   output logic            hit_o,
   output logic [ID_W-1:0] win_id_o,
   output lvl_t            win_lvl_o
);

   if (ARB_SPLIT) begin : g_split
      // stage 1: which levels are present; stage 2: first index at top level
      logic [LVL_TOP:1] seen;
      lvl_t             top;
      logic [ID_W-1:0]  pick;
      logic             found;

      always_comb begin
         seen = '0;
         for (int i = 0; i < N; i++) begin
            if (pend_i[i] && (lvl_i[i] != LVL_OFF)) seen[lvl_i[i]] = 1'b1;
         end
         top = LVL_OFF;
         for (int v = 1; v <= LVL_TOP; v++) begin
            if (seen[v]) top = LVL_W'(v);
         end
      end

      always_comb begin
         pick  = '0;
         found = 1'b0;
         for (int i = 0; i < N; i++) begin
            if (!found && pend_i[i] && (top != LVL_OFF) && (lvl_i[i] == top)) begin
               pick  = ID_W'(i);
               found = 1'b1;
            end
         end
      end

      assign hit_o     = found;
      assign win_id_o  = pick;
      assign win_lvl_o = top;
   end else begin : g_scan
      // single pass: strict compare keeps the lowest index on ties
      lvl_t            best_lvl;
      logic [ID_W-1:0] best_id;

      always_comb begin
         best_lvl = LVL_OFF;
         best_id  = '0;
         for (int i = 0; i < N; i++) begin
            if (pend_i[i] && (lvl_i[i] > best_lvl)) begin
               best_lvl = lvl_i[i];
               best_id  = ID_W'(i);
            end
         end
      end

      assign hit_o     = (best_lvl != LVL_OFF);
      assign win_id_o  = best_id;
      assign win_lvl_o = best_lvl;
   end

endmodule

// File: rtl/irq_ctx.sv
`timescale 1ns/1ps
module irq_ctx
   import irq_prio_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic take_i,
   input  lvl_t take_lvl_i,
   input  logic ret_i,
   input  logic gen_wr_i,
   input  logic gen_val_i,
   output logic gie_o,
   output lvl_t cur_o
);

   logic gie_q;
   lvl_t cur_q;
   ctx_t saved_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q   <= 1'b0;
         cur_q   <= LVL_OFF;
         saved_q <= '0;
      end else if (ret_i) begin
         gie_q <= saved_q.gie;
         cur_q <= saved_q.lvl;
      end else if (take_i) begin
         saved_q <= '{gie: gie_q, lvl: cur_q};
         gie_q   <= 1'b0;
         cur_q   <= take_lvl_i;
      end else if (gen_wr_i) begin
         gie_q <= gen_val_i;
      end
   end

   assign gie_o = gie_q;
   assign cur_o = cur_q;

   // R5
   take_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !ret_i) |=> (!gie_q && cur_q == $past(take_lvl_i)));

   // R5
   take_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !ret_i) |=> (saved_q.gie == $past(gie_q) && saved_q.lvl == $past(cur_q)));

   // R9
   ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_i |=> (gie_q == $past(saved_q.gie) && cur_q == $past(saved_q.lvl)));

endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter int N         = 8,
   parameter bit ARB_SPLIT = 1'b1,
   parameter int ID_W      = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     evt_i,
   input  logic             sw_wr_i,
   input  logic [ID_W-1:0]  sw_idx_i,
   input  logic             sw_pend_i,
   input  logic [LVL_W-1:0] sw_lvl_i,
   input  logic             gen_wr_i,
   input  logic             gen_val_i,
   input  logic             ack_i,
   input  logic             ret_i,
   output logic             irq_o,
   output logic [ID_W-1:0]  irq_id_o,
   output logic [LVL_W-1:0] irq_lvl_o,
   output logic             gie_o,
   output logic [LVL_W-1:0] cur_lvl_o,
   output logic [N-1:0]     pend_o
);

   if (N < 1 || N > 256) begin : g_bad_n
      $error("irq_prio_ctrl: N out of range 1..256");
   end
   if (ID_W < 1 || (1 << ID_W) < N) begin : g_bad_idw
      $error("irq_prio_ctrl: ID_W too narrow for N");
   end

   logic [N-1:0]    pend;
   lvl_t [N-1:0]    lvls;
   logic            hit;
   logic [ID_W-1:0] win_id;
   lvl_t            win_lvl;
   logic            gie;
   lvl_t            cur;
   logic            offer;
   logic            take;

   irq_req_bank #(.N(N), .ID_W(ID_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_i),
      .sw_wr_i   (sw_wr_i),
      .sw_idx_i  (sw_idx_i),
      .sw_pend_i (sw_pend_i),
      .sw_lvl_i  (sw_lvl_i),
      .ack_clr_i (take),
      .ack_idx_i (win_id),
      .pend_o    (pend),
      .lvl_o     (lvls)
   );

   irq_arbiter #(.N(N), .ID_W(ID_W), .ARB_SPLIT(ARB_SPLIT)) u_arb (
      .pend_i    (pend),
      .lvl_i     (lvls),
      .hit_o     (hit),
      .win_id_o  (win_id),
      .win_lvl_o (win_lvl)
   );

   assign offer = hit && gie && (win_lvl > cur);
   assign take  = ack_i && offer && !ret_i;

   irq_ctx u_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_i     (take),
      .take_lvl_i (win_lvl),
      .ret_i      (ret_i),
      .gen_wr_i   (gen_wr_i),
      .gen_val_i  (gen_val_i),
      .gie_o      (gie),
      .cur_o      (cur)
   );

   assign irq_o     = offer;
   assign irq_id_o  = win_id;
   assign irq_lvl_o = win_lvl;
   assign gie_o     = gie;
   assign cur_lvl_o = cur;
   assign pend_o    = pend;

   // R3
   offer_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (gie_o && irq_lvl_o > cur_lvl_o));

   // R4
   winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lvl_o != LVL_OFF) |-> pend_o[irq_id_o]);

   // R6
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !irq_o && !ret_i && !gen_wr_i) |=> (gie_o == $past(gie_o) && cur_lvl_o == $past(cur_lvl_o)));

endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;

   localparam int N  = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  evt_i = '0;
   logic          sw_wr_i = 1'b0;
   logic [IW-1:0] sw_idx_i = '0;
   logic          sw_pend_i = 1'b0;
   logic [2:0]    sw_lvl_i = '0;
   logic          gen_wr_i = 1'b0;
   logic          gen_val_i = 1'b0;
   logic          ack_i = 1'b0;
   logic          ret_i = 1'b0;
   logic          irq_o;
   logic [IW-1:0] irq_id_o;
   logic [2:0]    irq_lvl_o;
   logic          gie_o;
   logic [2:0]    cur_lvl_o;
   logic [N-1:0]  pend_o;

   irq_prio_ctrl #(.N(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
      .sw_wr_i(sw_wr_i), .sw_idx_i(sw_idx_i), .sw_pend_i(sw_pend_i), .sw_lvl_i(sw_lvl_i),
      .gen_wr_i(gen_wr_i), .gen_val_i(gen_val_i), .ack_i(ack_i), .ret_i(ret_i),
      .irq_o(irq_o), .irq_id_o(irq_id_o), .irq_lvl_o(irq_lvl_o),
      .gie_o(gie_o), .cur_lvl_o(cur_lvl_o), .pend_o(pend_o)
   );

   always #5 clk = ~clk;

   typedef struct {
      string      tag;
      logic       irq;
      logic [2:0] id;
      logic [2:0] lvl;
      logic       gie;
      logic [2:0] cur;
      logic [7:0] pend;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;

   task automatic cmp(input string tag, input string fld, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, fld, act, exp);
      end
   endtask

   // monitor: pops one expected item per falling edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         cmp(e.tag, "irq",  int'(irq_o),     int'(e.irq));
         cmp(e.tag, "id",   int'(irq_id_o),  int'(e.id));
         cmp(e.tag, "lvl",  int'(irq_lvl_o), int'(e.lvl));
         cmp(e.tag, "gie",  int'(gie_o),     int'(e.gie));
         cmp(e.tag, "cur",  int'(cur_lvl_o), int'(e.cur));
         cmp(e.tag, "pend", int'(pend_o),    int'(e.pend));
      end
   end

   // drive one cycle of stimulus, pulses drop just after the edge
   task automatic cyc(input logic [7:0] evt, input logic swwr, input int idx,
                      input logic swp, input int lv, input logic gw, input logic gv,
                      input logic ak, input logic rt);
      evt_i = evt; sw_wr_i = swwr; sw_idx_i = IW'(idx); sw_pend_i = swp;
      sw_lvl_i = 3'(lv); gen_wr_i = gw; gen_val_i = gv; ack_i = ak; ret_i = rt;
      @(posedge clk); #1;
      evt_i = '0; sw_wr_i = 1'b0; sw_pend_i = 1'b0; gen_wr_i = 1'b0;
      ack_i = 1'b0; ret_i = 1'b0;
   endtask

   // driver: queue the expectation, then let the monitor sample
   task automatic expect_st(input string tag, input logic irq, input int id, input int lvl,
                            input logic gie, input int cur, input logic [7:0] pend);
      exp_t e;
      e.tag = tag; e.irq = irq; e.id = 3'(id); e.lvl = 3'(lvl);
      e.gie = gie; e.cur = 3'(cur); e.pend = pend;
      exp_q.push_back(e);
      @(negedge clk); #1;
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      expect_st("R10 reset", 0, 0, 0, 0, 0, 8'h00);

      cyc(8'h08, 0, 0, 0, 0, 0, 0, 0, 0);
      expect_st("R1 latch while off", 0, 0, 0, 0, 0, 8'h08);

      cyc(8'h00, 1, 3, 1, 4, 0, 0, 0, 0);
      cyc(8'h00, 1, 5, 1, 4, 0, 0, 0, 0);
      expect_st("R7 write one no effect", 0, 3, 4, 0, 0, 8'h08);
      cyc(8'h00, 1, 1, 0, 2, 0, 0, 0, 0);

      cyc(8'h00, 0, 0, 0, 0, 1, 1, 0, 0);
      expect_st("R11/R3 enable offers", 1, 3, 4, 1, 0, 8'h08);

      cyc(8'h22, 0, 0, 0, 0, 0, 0, 0, 0);
      expect_st("R4 tie lowest index", 1, 3, 4, 1, 0, 8'h2A);

      cyc(8'h00, 1, 5, 1, 6, 0, 0, 0, 0);
      expect_st("R4 higher level wins", 1, 5, 6, 1, 0, 8'h2A);

      cyc(8'h00, 0, 0, 0, 0, 0, 0, 1, 0);
      expect_st("R5 acknowledge", 0, 3, 4, 0, 6, 8'h0A);

      cyc(8'h20, 0, 0, 0, 0, 0, 0, 0, 0);
      expect_st("R1 event in service", 0, 5, 6, 0, 6, 8'h2A);

      cyc(8'h00, 0, 0, 0, 0, 1, 1, 0, 0);
      expect_st("R3 equal level not offered", 0, 5, 6, 1, 6, 8'h2A);
      cyc(8'h00, 0, 0, 0, 0, 1, 0, 0, 0);

      cyc(8'h00, 0, 0, 0, 0, 0, 0, 0, 1);
      expect_st("R9 return retriggers", 1, 5, 6, 1, 0, 8'h2A);

      cyc(8'h20, 0, 0, 0, 0, 0, 0, 1, 0);
      expect_st("R8 event beats ack clear", 0, 5, 6, 0, 6, 8'h2A);

      cyc(8'h20, 1, 5, 0, 6, 0, 0, 0, 0);
      expect_st("R8 event beats sw clear", 0, 5, 6, 0, 6, 8'h2A);

      cyc(8'h00, 1, 5, 0, 6, 0, 0, 0, 0);
      expect_st("R7 sw clear", 0, 3, 4, 0, 6, 8'h0A);

      cyc(8'h00, 0, 0, 0, 0, 0, 0, 0, 1);
      expect_st("R9 return restores", 1, 3, 4, 1, 0, 8'h0A);

      cyc(8'h00, 1, 3, 1, 0, 0, 0, 0, 0);
      expect_st("R2 level zero skipped", 1, 1, 2, 1, 0, 8'h0A);

      cyc(8'h00, 0, 0, 0, 0, 1, 0, 0, 0);
      expect_st("R11 disable", 0, 1, 2, 0, 0, 8'h0A);

      cyc(8'h00, 0, 0, 0, 0, 0, 0, 1, 0);
      expect_st("R6 ack ignored", 0, 1, 2, 0, 0, 8'h0A);

      cyc(8'h00, 0, 0, 0, 0, 1, 1, 0, 0);
      expect_st("R11 re-enable", 1, 1, 2, 1, 0, 8'h0A);

      cyc(8'h00, 0, 0, 0, 0, 0, 0, 1, 1);
      expect_st("R9 return beats ack", 1, 1, 2, 1, 0, 8'h0A);

      cyc(8'h00, 0, 0, 0, 0, 0, 0, 1, 0);
      expect_st("R5/R2 ack leaves level-0 source", 0, 0, 0, 0, 2, 8'h08);

      cyc(8'h02, 0, 0, 0, 0, 0, 0, 0, 1);
      expect_st("R1/R9 event with return", 1, 1, 2, 1, 0, 8'h0A);

      wait (exp_q.size() == 0);
      @(negedge clk); #1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule